// File: doc/BRIEF.md
# XON/XOFF Software Flow Control Engine

This block sits between a UART's receive path and its transmit path and handles in-band software flow control. On the receive side it inspects each incoming character against four programmable control characters (two "resume" characters and two "pause" characters). Depending on a 4-bit mode field, it recognises a pause or resume condition either as a single character or as an ordered pair of characters. A recognised pause sets a transmit-halt flag and a recognised resume clears it. Characters consumed as flow control are marked and kept off the forwarded receive stream. An optional detector flags any received character that equals a programmed special character.

On the transmit side, a request for a pause or resume message makes the block emit one control character or a two-character pair on a ready/valid output stream. These characters go out ahead of normal data. While the halt flag is set, normal data is held back, but flow-control characters still go out.

The mode field splits into two halves. Bits [3:2] pick what is transmitted and bits [1:0] pick what the receiver compares. Software is expected to write all zeros before it programs a new non-zero mode. Any mode change abandons a half-received pair.

Top module: `swfc_engine`

## Requirements
- R1: While reset is asserted, and after it is released, `tx_halt`, `rx_fwd_valid`, `rx_fc_hit`, `spec_hit` and `out_valid` are 0 (with no data offered) and `fc_req_ready` is 1.
- R2: Receive-mode code `mode[1:0]` = 10 compares against `xon1`/`xoff1`, and 01 compares against `xon2`/`xoff2`. One cycle after a valid character: a pause match pulses `rx_fc_hit` and sets `tx_halt`; a resume match pulses `rx_fc_hit` and clears `tx_halt`; any other character pulses `rx_fwd_valid` with `rx_fwd_data` equal to the character.
- R3: With `mode[1:0]` = 11 and `mode[3:2]` = 10 or 01, either `xon1` or `xon2` alone counts as resume, and either `xoff1` or `xoff2` alone counts as pause.
- R4: With `mode[1:0]` = 11 and `mode[3:2]` = 11 or 00, only the pair `xon1` then `xon2` counts as resume, and only `xoff1` then `xoff2` counts as pause. The first character of a pair is forwarded, and the second is flagged as flow control.
- R5: In pair mode, a character that follows a first-of-pair but does not complete it discards the partial match and is itself evaluated as a possible first character.
- R6: A change of `mode` abandons any partial pair, so a second-of-pair character that arrives with or after the change is forwarded.
- R7: With `mode[1:0]` = 00, every received character is forwarded and `tx_halt` is 0 from the next cycle on.
- R8: When `spec_en` is 1, a received character equal to `spec_char` pulses `spec_hit` one cycle later. A non-equal character, or `spec_en` at 0, gives no pulse.
- R9: On an accepted request (`fc_req_xoff` 1 = pause, 0 = resume), transmit code `mode[3:2]` = 10 emits `xon1`/`xoff1`, 01 emits `xon2`/`xoff2`, and 11 emits the first then the second character of the pair. Code 00 accepts the request and emits nothing.
- R10: While request characters are pending, `fc_req_ready` and `data_ready` are 0 and `out_data` holds under back-pressure. The pair is never split by data, and data resumes after the last control character.
- R11: While `tx_halt` is 1, no data is offered on the output (`out_valid` from data and `data_ready` are 0), but requested control characters are still emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 4 | [3:2] transmit selection, [1:0] receive selection |
| xon1 | input | 8 | First resume character |
| xon2 | input | 8 | Second resume character |
| xoff1 | input | 8 | First pause character |
| xoff2 | input | 8 | Second pause character |
| spec_en | input | 1 | Special character detect enable |
| spec_char | input | 8 | Special character value |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_fwd_valid | output | 1 | Character to be passed on to the receive buffer |
| rx_fwd_data | output | 8 | Forwarded character |
| rx_fc_hit | output | 1 | Character consumed as flow control |
| spec_hit | output | 1 | Special character seen |
| tx_halt | output | 1 | Remote side asked to pause transmit |
| fc_req_valid | input | 1 | Request to send a flow-control message |
| fc_req_xoff | input | 1 | 1 = pause message, 0 = resume message |
| fc_req_ready | output | 1 | Request accepted |
| data_valid | input | 1 | Normal transmit data offered |
| data_in | input | 8 | Normal transmit data |
| data_ready | output | 1 | Normal data taken |
| out_valid | output | 1 | Character for the serializer |
| out_data | output | 8 | Outgoing character |
| out_ready | input | 1 | Serializer accepts character |

## Verification
The receive matcher is driven with a character stream that moves through every receive code. Each code gets pause, resume and unrelated characters, so the stream shows which character set each code compares. Code 11 is run under each transmit code to show single-character matching apart from pair matching. In pair mode the stream includes a broken pair, a repeated first character, a pair completed after a stray first character, and a pair cut by a mode change; these separate a correct restart from a stale partial match. The transmit side is tried with every transmit code, with data waiting during control output, with back-pressure in the middle of a pair, and with the halt flag set.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  // Two-bit selection code used by both halves of the mode field
  typedef enum logic [1:0] {
    FC_NONE = 2'b00,
    FC_SET2 = 2'b01,
    FC_SET1 = 2'b10,
    FC_BOTH = 2'b11
  } fc_sel_e;
endpackage

// File: rtl/swfc_rx_match.sv
module swfc_rx_match
  import swfc_pkg::*;
#(
  parameter int  CW          = 8,
  parameter bit  HAS_SPECIAL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fc_sel_e       tx_sel,
  input  fc_sel_e       rx_sel,
  input  logic          mode_chg,
  input  logic [CW-1:0] xon1,
  input  logic [CW-1:0] xon2,
  input  logic [CW-1:0] xoff1,
  input  logic [CW-1:0] xoff2,
  input  logic          spec_en,
  input  logic [CW-1:0] spec_char,
  input  logic          rx_valid,
  input  logic [CW-1:0] rx_data,
  output logic          rx_fwd_valid,
  output logic [CW-1:0] rx_fwd_data,
  output logic          rx_fc_hit,
  output logic          spec_hit,
  output logic          tx_halt
);

  logic pend_on_q, pend_off_q, pend_on_v, pend_off_v, pend_on_n, pend_off_n;
  logic halt_q, halt_n;
  logic fwd_q, hit_q;
  logic [CW-1:0] data_q;
  logic m_on1, m_on2, m_off1, m_off2;
  logic seq_mode, hit_on, hit_off;

  assign m_on1  = (rx_data == xon1);
  assign m_on2  = (rx_data == xon2);
  assign m_off1 = (rx_data == xoff1);
  assign m_off2 = (rx_data == xoff2);

  always_comb begin
    pend_on_v  = pend_on_q  & ~mode_chg;
    pend_off_v = pend_off_q & ~mode_chg;
    seq_mode   = (rx_sel == FC_BOTH) && ((tx_sel == FC_BOTH) || (tx_sel == FC_NONE));
    hit_on     = 1'b0;
    hit_off    = 1'b0;
    case (rx_sel)
      FC_SET1: begin hit_on = m_on1; hit_off = m_off1; end
      FC_SET2: begin hit_on = m_on2; hit_off = m_off2; end
      FC_BOTH: begin
        if (seq_mode) begin
          hit_on  = pend_on_v  & m_on2;
          hit_off = pend_off_v & m_off2;
        end else begin
          hit_on  = m_on1  | m_on2;
          hit_off = m_off1 | m_off2;
        end
      end
      default: ;
    endcase
    hit_on  = hit_on  & rx_valid;
    hit_off = hit_off & rx_valid;

    pend_on_n  = pend_on_v;
    pend_off_n = pend_off_v;
    if (!seq_mode) begin
      pend_on_n  = 1'b0;
      pend_off_n = 1'b0;
    end else if (rx_valid) begin
      // a character that does not complete a pair is tried as a fresh first
      pend_on_n  = ~(hit_on | hit_off) & m_on1;
      pend_off_n = ~(hit_on | hit_off) & m_off1;
    end

    halt_n = halt_q;
    if (rx_sel == FC_NONE) halt_n = 1'b0;
    else if (hit_off)      halt_n = 1'b1;
    else if (hit_on)       halt_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_on_q  <= 1'b0;
      pend_off_q <= 1'b0;
      halt_q     <= 1'b0;
      fwd_q      <= 1'b0;
      hit_q      <= 1'b0;
    end else begin
      pend_on_q  <= pend_on_n;
      pend_off_q <= pend_off_n;
      halt_q     <= halt_n;
      fwd_q      <= rx_valid & ~(hit_on | hit_off);
      hit_q      <= hit_on | hit_off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (rx_valid) data_q <= rx_data;
  end

  generate
    if (HAS_SPECIAL) begin : g_spec
      logic spec_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) spec_q <= 1'b0;
        else        spec_q <= rx_valid & spec_en & (rx_data == spec_char);
      end
      assign spec_hit = spec_q;
    end else begin : g_nospec
      logic unused_spec;
      assign unused_spec = spec_en ^ (^spec_char);
      assign spec_hit    = 1'b0;
    end
  endgenerate

  assign rx_fwd_valid = fwd_q;
  assign rx_fwd_data  = data_q;
  assign rx_fc_hit    = hit_q;
  assign tx_halt      = halt_q;

endmodule

// File: rtl/swfc_tx_insert.sv
module swfc_tx_insert
  import swfc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fc_sel_e       tx_sel,
  input  logic [CW-1:0] xon1,
  input  logic [CW-1:0] xon2,
  input  logic [CW-1:0] xoff1,
  input  logic [CW-1:0] xoff2,
  input  logic          tx_halt,
  input  logic          fc_req_valid,
  input  logic          fc_req_xoff,
  output logic          fc_req_ready,
  input  logic          data_valid,
  input  logic [CW-1:0] data_in,
  output logic          data_ready,
  output logic          out_valid,
  output logic [CW-1:0] out_data,
  input  logic          out_ready
);

  logic [1:0]    cnt_q, cnt_n, n_chars;
  logic [CW-1:0] slot0_q, slot1_q, slot0_n, slot1_n, first_c, second_c;
  logic          pending, accept, fire, slot_en;

  always_comb begin
    pending  = (cnt_q != 2'd0);
    accept   = fc_req_valid & ~pending;
    fire     = pending & out_ready;
    second_c = fc_req_xoff ? xoff2 : xon2;
    first_c  = fc_req_xoff ? xoff1 : xon1;
    if (tx_sel == FC_SET2) first_c = second_c;
    case (tx_sel)
      FC_NONE: n_chars = 2'd0;
      FC_BOTH: n_chars = 2'd2;
      default: n_chars = 2'd1;
    endcase

    cnt_n   = cnt_q;
    slot0_n = slot0_q;
    slot1_n = slot1_q;
    slot_en = 1'b0;
    if (accept) begin
      cnt_n   = n_chars;
      slot0_n = first_c;
      slot1_n = second_c;
      slot_en = 1'b1;
    end else if (fire) begin
      cnt_n   = cnt_q - 2'd1;
      slot0_n = slot1_q;
      slot_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= 2'd0;
    else        cnt_q <= cnt_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot0_q <= '0;
      slot1_q <= '0;
    end else if (slot_en) begin
      slot0_q <= slot0_n;
      slot1_q <= slot1_n;
    end
  end

  assign fc_req_ready = ~pending;
  assign out_valid    = pending | (data_valid & ~tx_halt);
  assign out_data     = pending ? slot0_q : data_in;
  assign data_ready   = ~pending & ~tx_halt & out_ready;

endmodule

// File: rtl/swfc_engine.sv
module swfc_engine
  import swfc_pkg::*;
#(
  parameter int CW          = 8,
  parameter bit HAS_SPECIAL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    mode,
  input  logic [CW-1:0] xon1,
  input  logic [CW-1:0] xon2,
  input  logic [CW-1:0] xoff1,
  input  logic [CW-1:0] xoff2,
  input  logic          spec_en,
  input  logic [CW-1:0] spec_char,
  input  logic          rx_valid,
  input  logic [CW-1:0] rx_data,
  output logic          rx_fwd_valid,
  output logic [CW-1:0] rx_fwd_data,
  output logic          rx_fc_hit,
  output logic          spec_hit,
  output logic          tx_halt,
  input  logic          fc_req_valid,
  input  logic          fc_req_xoff,
  output logic          fc_req_ready,
  input  logic          data_valid,
  input  logic [CW-1:0] data_in,
  output logic          data_ready,
  output logic          out_valid,
  output logic [CW-1:0] out_data,
  input  logic          out_ready
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic [3:0] mode_q;
  logic       mode_chg;
  fc_sel_e    tx_sel, rx_sel;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) mode_q <= 4'd0;
    else            mode_q <= mode;
  end

  assign mode_chg = (mode != mode_q);
  assign tx_sel   = fc_sel_e'(mode[3:2]);
  assign rx_sel   = fc_sel_e'(mode[1:0]);

  swfc_rx_match #(.CW(CW), .HAS_SPECIAL(HAS_SPECIAL)) u_rx (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .tx_sel       (tx_sel),
    .rx_sel       (rx_sel),
    .mode_chg     (mode_chg),
    .xon1         (xon1),
    .xon2         (xon2),
    .xoff1        (xoff1),
    .xoff2        (xoff2),
    .spec_en      (spec_en),
    .spec_char    (spec_char),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_fwd_valid (rx_fwd_valid),
    .rx_fwd_data  (rx_fwd_data),
    .rx_fc_hit    (rx_fc_hit),
    .spec_hit     (spec_hit),
    .tx_halt      (tx_halt)
  );

  swfc_tx_insert #(.CW(CW)) u_tx (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .tx_sel       (tx_sel),
    .xon1         (xon1),
    .xon2         (xon2),
    .xoff1        (xoff1),
    .xoff2        (xoff2),
    .tx_halt      (tx_halt),
    .fc_req_valid (fc_req_valid),
    .fc_req_xoff  (fc_req_xoff),
    .fc_req_ready (fc_req_ready),
    .data_valid   (data_valid),
    .data_in      (data_in),
    .data_ready   (data_ready),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_ready    (out_ready)
  );

endmodule

// File: rtl/swfc_engine_chk.sv
module swfc_engine_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    mode,
  input logic          spec_en,
  input logic [CW-1:0] spec_char,
  input logic          rx_valid,
  input logic [CW-1:0] rx_data,
  input logic          rx_fwd_valid,
  input logic          rx_fc_hit,
  input logic          spec_hit,
  input logic          tx_halt,
  input logic          fc_req_ready,
  input logic          data_ready,
  input logic          out_valid,
  input logic [CW-1:0] out_data,
  input logic          out_ready
);

  assert_fwd_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fwd_valid || rx_fc_hit) |-> $past(rx_valid));

  assert_fwd_or_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_fwd_valid && rx_fc_hit));

  assert_halt_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_halt) |-> rx_fc_hit);

  assert_halt_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_halt) |-> (rx_fc_hit || $past(mode[1:0] == 2'b00)));

  assert_rx_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1:0] == 2'b00) |=> !tx_halt);

  assert_spec_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spec_hit |-> $past(spec_en && rx_valid && (rx_data == spec_char)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fc_req_ready && out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_req_ready |-> (!data_ready && out_valid));

  assert_halt_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_halt |-> !data_ready);

endmodule

bind swfc_engine swfc_engine_chk #(.CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode         (mode),
  .spec_en      (spec_en),
  .spec_char    (spec_char),
  .rx_valid     (rx_valid),
  .rx_data      (rx_data),
  .rx_fwd_valid (rx_fwd_valid),
  .rx_fc_hit    (rx_fc_hit),
  .spec_hit     (spec_hit),
  .tx_halt      (tx_halt),
  .fc_req_ready (fc_req_ready),
  .data_ready   (data_ready),
  .out_valid    (out_valid),
  .out_data     (out_data),
  .out_ready    (out_ready)
);

// File: tb/swfc_engine_bench.sv
`timescale 1ns/1ps
module swfc_engine_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] mode;
  logic [7:0] xon1, xon2, xoff1, xoff2, spec_char, rx_data, data_in;
  logic       spec_en, rx_valid, fc_req_valid, fc_req_xoff, data_valid, out_ready;
  logic       rx_fwd_valid, rx_fc_hit, spec_hit, tx_halt, fc_req_ready, data_ready, out_valid;
  logic [7:0] rx_fwd_data, out_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  swfc_engine u_swfc_engine (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .xon1(xon1), .xon2(xon2), .xoff1(xoff1), .xoff2(xoff2),
    .spec_en(spec_en), .spec_char(spec_char),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_fwd_valid(rx_fwd_valid), .rx_fwd_data(rx_fwd_data),
    .rx_fc_hit(rx_fc_hit), .spec_hit(spec_hit), .tx_halt(tx_halt),
    .fc_req_valid(fc_req_valid), .fc_req_xoff(fc_req_xoff), .fc_req_ready(fc_req_ready),
    .data_valid(data_valid), .data_in(data_in), .data_ready(data_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  // {mode, character, 0, expect forward, expect flow hit, expect halt after}
  localparam logic [15:0] VEC [0:23] = '{
    {4'b0000, 8'h13, 4'h4}, {4'b0010, 8'h13, 4'h3}, {4'b0010, 8'h14, 4'h5},
    {4'b0010, 8'h11, 4'h2}, {4'b0001, 8'h14, 4'h3}, {4'b0001, 8'h11, 4'h5},
    {4'b0001, 8'h12, 4'h2}, {4'b1011, 8'h14, 4'h3}, {4'b1011, 8'h11, 4'h2},
    {4'b0111, 8'h13, 4'h3}, {4'b0111, 8'h12, 4'h2}, {4'b1111, 8'h13, 4'h4},
    {4'b1111, 8'h14, 4'h3}, {4'b1111, 8'h11, 4'h5}, {4'b1111, 8'h41, 4'h5},
    {4'b1111, 8'h12, 4'h5}, {4'b1111, 8'h11, 4'h5}, {4'b1111, 8'h11, 4'h5},
    {4'b1111, 8'h12, 4'h2}, {4'b0011, 8'h13, 4'h4}, {4'b0011, 8'h14, 4'h3},
    {4'b0011, 8'h11, 4'h5}, {4'b1111, 8'h12, 4'h5}, {4'b0000, 8'h55, 4'h4}
  };

  function automatic string row_tag(int i);
    if (i == 0 || i == 23)    return "R7";
    if (i == 22)              return "R6";
    if (i >= 14 && i <= 17)   return "R5";
    if (i <= 6)               return "R2";
    if (i <= 10)              return "R3";
    return "R4";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_rx(input logic [7:0] c);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = c;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic req(input logic xoff);
    @(negedge clk);
    fc_req_valid = 1'b1;
    fc_req_xoff  = xoff;
    chk("R10 request ready when idle", fc_req_ready, 1);
    @(negedge clk);
    fc_req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 4'd0;
    xon1 = 8'h11; xon2 = 8'h12; xoff1 = 8'h13; xoff2 = 8'h14;
    spec_en = 1'b0; spec_char = 8'h2A; rx_valid = 1'b0; rx_data = 8'h00;
    fc_req_valid = 1'b0; fc_req_xoff = 1'b0; data_valid = 1'b0; data_in = 8'h00;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 halt in reset", tx_halt, 0);
    chk("R1 fwd in reset", rx_fwd_valid, 0);
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 req ready in reset", fc_req_ready, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 halt after reset", tx_halt, 0);
    chk("R1 hit after reset", rx_fc_hit, 0);
    chk("R1 spec after reset", spec_hit, 0);

    // receive vector walk
    for (int i = 0; i < 24; i++) begin
      mode = VEC[i][15:12];
      send_rx(VEC[i][11:4]);
      chk({row_tag(i), " forward"}, rx_fwd_valid, VEC[i][2]);
      chk({row_tag(i), " flow hit"}, rx_fc_hit, VEC[i][1]);
      chk({row_tag(i), " halt"}, tx_halt, VEC[i][0]);
      if (VEC[i][2]) chk({row_tag(i), " forward data"}, rx_fwd_data, VEC[i][11:4]);
    end

    // R8: special character detect
    spec_en = 1'b1;
    send_rx(8'h2A);
    chk("R8 match pulses", spec_hit, 1);
    chk("R8 match still forwarded", rx_fwd_valid, 1);
    send_rx(8'h2B);
    chk("R8 other char no pulse", spec_hit, 0);
    spec_en = 1'b0;
    send_rx(8'h2A);
    chk("R8 disabled no pulse", spec_hit, 0);

    // R9/R10: single character, set 1, pause
    mode = 4'b1000;
    req(1'b1);
    data_valid = 1'b1; data_in = 8'hAA;
    chk("R9 set1 pause char", out_data, 8'h13);
    chk("R10 out valid pending", out_valid, 1);
    chk("R10 data held", data_ready, 0);
    chk("R10 req blocked", fc_req_ready, 0);
    @(negedge clk);
    chk("R10 data after control", out_data, 8'hAA);
    chk("R10 data ready resumes", data_ready, 1);
    data_valid = 1'b0;

    // R9/R10: pair, resume, with back-pressure
    mode = 4'b1100;
    out_ready = 1'b0;
    req(1'b0);
    data_valid = 1'b1; data_in = 8'hBB;
    chk("R9 pair first char", out_data, 8'h11);
    @(negedge clk);
    chk("R10 held under back-pressure", out_data, 8'h11);
    chk("R10 valid held", out_valid, 1);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9 pair second char", out_data, 8'h12);
    chk("R10 pair not split", data_ready, 0);
    @(negedge clk);
    chk("R10 data after pair", out_data, 8'hBB);
    data_valid = 1'b0;

    // R9: set 2 pause
    mode = 4'b0100;
    req(1'b1);
    chk("R9 set2 pause char", out_data, 8'h14);
    chk("R9 set2 valid", out_valid, 1);
    @(negedge clk);
    chk("R9 single char done", fc_req_ready, 1);

    // R9: transmit code 00 emits nothing
    mode = 4'b0000;
    req(1'b1);
    chk("R9 none still ready", fc_req_ready, 1);
    chk("R9 none no output", out_valid, 0);

    // R11: halt blocks data, not control
    mode = 4'b1010;
    send_rx(8'h13);
    chk("R11 halt set", tx_halt, 1);
    data_valid = 1'b1; data_in = 8'hCC;
    #1;
    chk("R11 data blocked valid", out_valid, 0);
    chk("R11 data blocked ready", data_ready, 0);
    req(1'b0);
    chk("R11 control while halted", out_data, 8'h11);
    chk("R11 control valid while halted", out_valid, 1);
    @(negedge clk);
    chk("R11 still blocked after control", out_valid, 0);
    send_rx(8'h11);
    chk("R11 halt cleared", tx_halt, 0);
    chk("R11 data flows", out_data, 8'hCC);
    chk("R11 data valid", out_valid, 1);
    data_valid = 1'b0;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule